// File: doc/BRIEF.md
# Serial Divider-Ratio Loader

This block receives synthesizer divide ratios over a three-wire serial link made of a data line, a serial clock and a load strobe. The three lines are treated as asynchronous to the block clock. They pass through synchronizer stages, and the block acts on the rising edges of the serial clock and of the load strobe. Each rising edge of the serial clock moves one data bit into a shared shift register. The most significant bit is sent first, so the last bit sent sits in the lowest position of the register.

A rising edge of the load strobe transfers the register contents to one of two destinations. The last bit received decides which one. When that bit is one, a 16-bit reference frame is decoded: a reference count plus a prescaler-select bit. When that bit is zero, a 19-bit divider frame is decoded: a swallow count plus a programmable count.

A frame that carries a prohibited ratio is not applied. The destination keeps its previous contents, and an error flag is raised. The flag stays set until a frame is accepted.

Top module: `sdl_loader`

## Requirements
- R1: On each rising edge of `ser_clk_i`, the bit on `ser_data_i` enters the lowest position of the shift register, and every older bit moves up one position. Frames are therefore sent most significant bit first.
- R2: On a rising edge of `ser_le_i`, bit 0 of the shift register (the last bit sent) selects the destination. A value of 1 selects the reference latch and a value of 0 selects the divider latch. Only the selected latch can change.
- R3: In a reference frame, bit 0 is the select bit, bit 1 is output on `presc_sel_o`, and bits 15:2 form the reference count on `ref_div_o`. Bits received before the last 16 have no effect on a reference load.
- R4: In a divider frame, bits 7:1 form the swallow count on `swallow_o` and bits 18:8 form the programmable count on `prog_div_o`.
- R5: A reference frame with a count below 8 is rejected. The reference outputs keep their values and `ratio_err_o` becomes 1. A count of 8 is accepted.
- R6: A divider frame with a programmable count below 16 is rejected. The divider outputs keep their values and `ratio_err_o` becomes 1. A count of 16 is accepted.
- R7: A divider frame whose swallow count is not smaller than its programmable count is rejected in the same way as in R6.
- R8: An accepted load clears `ratio_err_o`. Without a load, the flag and all latched outputs hold their values.
- R9: While `rst_n` is low, all outputs are 0.
- R10: A pin edge takes effect on the outputs exactly three rising edges of `clk` after it is first sampled: two synchronizer stages, then one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 1 | Serial data line |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_le_i | input | 1 | Load strobe; a rising edge transfers the frame |
| ref_div_o | output | 14 | Latched reference count |
| presc_sel_o | output | 1 | Latched prescaler-select bit |
| swallow_o | output | 7 | Latched swallow count |
| prog_div_o | output | 11 | Latched programmable count |
| ratio_err_o | output | 1 | Set by a rejected frame, cleared by an accepted frame |

## Verification
The hardest cases to reach are the rejections, where a latch must keep its old contents while the error flag moves. Each such case is therefore placed directly after an accepted frame with different field values, so that a wrongly applied frame changes visible outputs. Counts one step on either side of each limit are sent back to back. A 19-bit stream with a reference frame in its low bits checks that older bits are discarded. A bare load pulse with no new bits checks that the same register contents are transferred again. A cycle-accurate model compares every output on every clock, which also covers the three-edge latency.

// File: rtl/sdl_pkg.sv
package sdl_pkg;

  // Destination encoded by the final bit of a frame
  typedef enum logic {
    DEST_DIV = 1'b0,
    DEST_REF = 1'b1
  } dest_e;

  function automatic int unsigned max_w(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdl_sync.sv
module sdl_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter bit EDGE   = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sig_o
);

  localparam int DEPTH = STAGES + (EDGE ? 1 : 0);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [DEPTH-1:0] chain_q;
    logic [DEPTH-1:0] chain_d;

    always_comb begin
      chain_d = {chain_q[DEPTH-2:0], async_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= chain_d;
      end
    end

    if (EDGE) begin : g_edge
      assign sig_o[g] = chain_q[STAGES-1] & ~chain_q[STAGES];

      // R10
      edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sig_o[g] |=> !sig_o[g]);
    end else begin : g_level
      assign sig_o[g] = chain_q[STAGES-1];
    end
  end

endmodule

// File: rtl/sdl_shift.sv
module sdl_shift #(
  parameter int SR_W = 19
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            bit_i,
  output logic [SR_W-1:0] sr_o
);

  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (shift_en) begin
      sr_d = {sr_q[SR_W-2:0], bit_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else begin
      sr_q <= sr_d;
    end
  end

  assign sr_o = sr_q;

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (sr_q[0] == $past(bit_i)) && (sr_q[SR_W-1:1] == $past(sr_q[SR_W-2:0])));

  // R8
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sr_q));

endmodule

// File: rtl/sdl_latch.sv
module sdl_latch
  import sdl_pkg::*;
#(
  parameter int REF_W   = 14,
  parameter int SWL_W   = 7,
  parameter int PRG_W   = 11,
  parameter int REF_MIN = 8,
  parameter int PRG_MIN = 16,
  parameter int SR_W    = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [SR_W-1:0]  sr_i,
  output logic [REF_W-1:0] ref_o,
  output logic             sw_o,
  output logic [SWL_W-1:0] swl_o,
  output logic [PRG_W-1:0] prg_o,
  output logic             err_o
);

  localparam int REF_LSB = 2;
  localparam int SWL_LSB = 1;
  localparam int PRG_LSB = SWL_LSB + SWL_W;

  dest_e            dest;
  logic             fr_sw;
  logic [REF_W-1:0] fr_ref;
  logic [SWL_W-1:0] fr_swl;
  logic [PRG_W-1:0] fr_prg;
  logic             ref_ok;
  logic             div_ok;

  logic [REF_W-1:0] ref_q, ref_d;
  logic             sw_q, sw_d;
  logic [SWL_W-1:0] swl_q, swl_d;
  logic [PRG_W-1:0] prg_q, prg_d;
  logic             err_q, err_d;

  always_comb begin
    dest   = dest_e'(sr_i[0]);
    fr_sw  = sr_i[1];
    fr_ref = sr_i[REF_LSB +: REF_W];
    fr_swl = sr_i[SWL_LSB +: SWL_W];
    fr_prg = sr_i[PRG_LSB +: PRG_W];
    ref_ok = (fr_ref >= REF_W'(REF_MIN));
    div_ok = (fr_prg >= PRG_W'(PRG_MIN)) && (PRG_W'(fr_swl) < fr_prg);
  end

  always_comb begin
    ref_d = ref_q;
    sw_d  = sw_q;
    swl_d = swl_q;
    prg_d = prg_q;
    err_d = err_q;
    if (load_en) begin
      if (dest == DEST_REF) begin
        if (ref_ok) begin
          ref_d = fr_ref;
          sw_d  = fr_sw;
          err_d = 1'b0;
        end else begin
          err_d = 1'b1;
        end
      end else begin
        if (div_ok) begin
          swl_d = fr_swl;
          prg_d = fr_prg;
          err_d = 1'b0;
        end else begin
          err_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      sw_q  <= 1'b0;
      swl_q <= '0;
      prg_q <= '0;
      err_q <= 1'b0;
    end else begin
      ref_q <= ref_d;
      sw_q  <= sw_d;
      swl_q <= swl_d;
      prg_q <= prg_d;
      err_q <= err_d;
    end
  end

  assign ref_o = ref_q;
  assign sw_o  = sw_q;
  assign swl_o = swl_q;
  assign prg_o = prg_q;
  assign err_o = err_q;

  // R2
  ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && sr_i[0]) |=> $stable(ref_q) && $stable(sw_q));

  // R2
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && !sr_i[0]) |=> $stable(swl_q) && $stable(prg_q));

  // R5
  ref_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_q) |-> (ref_q >= REF_W'(REF_MIN)));

  // R6
  prg_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prg_q) |-> (prg_q >= PRG_W'(PRG_MIN)));

  // R7
  swl_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(prg_q) || !$stable(swl_q)) |-> (PRG_W'(swl_q) < prg_q));

  // R8
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_q) |-> $past(load_en));

endmodule

// File: rtl/sdl_loader.sv
module sdl_loader #(
  parameter int REF_W   = 14,
  parameter int SWL_W   = 7,
  parameter int PRG_W   = 11,
  parameter int REF_MIN = 8,
  parameter int PRG_MIN = 16,
  parameter int STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_data_i,
  input  logic             ser_clk_i,
  input  logic             ser_le_i,
  output logic [REF_W-1:0] ref_div_o,
  output logic             presc_sel_o,
  output logic [SWL_W-1:0] swallow_o,
  output logic [PRG_W-1:0] prog_div_o,
  output logic             ratio_err_o
);

  localparam int REF_FRAME = REF_W + 2;
  localparam int DIV_FRAME = SWL_W + PRG_W + 1;
  localparam int SR_W      = int'(sdl_pkg::max_w(REF_FRAME, DIV_FRAME));

  logic [1:0]      rst_pipe_q;
  logic            rst_int_n;
  logic [0:0]      data_sync;
  logic [1:0]      edge_sync;
  logic            shift_en;
  logic            load_en;
  logic [SR_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_pipe_q[1];

  sdl_sync #(.W(1), .STAGES(STAGES), .EDGE(1'b0)) u_data_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i (ser_data_i),
    .sig_o   (data_sync)
  );

  sdl_sync #(.W(2), .STAGES(STAGES), .EDGE(1'b1)) u_edge_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .async_i ({ser_le_i, ser_clk_i}),
    .sig_o   (edge_sync)
  );

  assign shift_en = edge_sync[0];
  assign load_en  = edge_sync[1];

  sdl_shift #(.SR_W(SR_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .shift_en (shift_en),
    .bit_i    (data_sync[0]),
    .sr_o     (sr)
  );

  sdl_latch #(
    .REF_W   (REF_W),
    .SWL_W   (SWL_W),
    .PRG_W   (PRG_W),
    .REF_MIN (REF_MIN),
    .PRG_MIN (PRG_MIN),
    .SR_W    (SR_W)
  ) u_latch (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load_en (load_en),
    .sr_i    (sr),
    .ref_o   (ref_div_o),
    .sw_o    (presc_sel_o),
    .swl_o   (swallow_o),
    .prg_o   (prog_div_o),
    .err_o   (ratio_err_o)
  );

  // R9
  reset_zero_chk: assert property (@(posedge clk)
    !rst_n |-> (ref_div_o == '0) && (prog_div_o == '0) && !ratio_err_o);

endmodule

// File: tb/sdl_loader_tb.sv
`timescale 1ns/1ps
module sdl_loader_tb;

  logic        clk;
  logic        rst_n;
  logic        ser_data;
  logic        ser_clk;
  logic        ser_le;
  logic [13:0] ref_div;
  logic        presc_sel;
  logic [6:0]  swallow;
  logic [10:0] prog_div;
  logic        ratio_err;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  bit done  = 0;

  sdl_loader u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_data_i  (ser_data),
    .ser_clk_i   (ser_clk),
    .ser_le_i    (ser_le),
    .ref_div_o   (ref_div),
    .presc_sel_o (presc_sel),
    .swallow_o   (swallow),
    .prog_div_o  (prog_div),
    .ratio_err_o (ratio_err)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: queue of pin samples (front = newest), integers for state
  logic [2:0] hist[$];
  int m_sr, m_ref, m_sw, m_swl, m_prg, m_err;
  bit model_on = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{3'b000, 3'b000, 3'b000};
      m_sr = 0; m_ref = 0; m_sw = 0; m_swl = 0; m_prg = 0; m_err = 0;
      model_on = 1;
    end else begin
      // R10: act on the pair (second, third) newest samples
      logic [2:0] s_new, s_old;
      s_new = hist[1];
      s_old = hist[2];
      if (s_new[2] && !s_old[2]) begin
        if (m_sr % 2 == 1) begin
          int r;
          r = (m_sr / 4) % 16384;
          if (r >= 8) begin m_ref = r; m_sw = (m_sr / 2) % 2; m_err = 0; end
          else m_err = 1;
        end else begin
          int a, n;
          a = (m_sr / 2) % 128;
          n = (m_sr / 256) % 2048;
          if (n >= 16 && a < n) begin m_swl = a; m_prg = n; m_err = 0; end
          else m_err = 1;
        end
      end
      if (s_new[1] && !s_old[1]) m_sr = ((m_sr * 2) + s_new[0]) % (1 << 19);
      hist.push_front({ser_le, ser_clk, ser_data});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && model_on && !done) begin
      chk("R3", "ref_div", ref_div, m_ref);
      chk("R3", "presc_sel", presc_sel, m_sw);
      chk("R4", "swallow", swallow, m_swl);
      chk("R4", "prog_div", prog_div, m_prg);
      chk("R5", "ratio_err", ratio_err, m_err);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  function automatic logic [18:0] ref_frame(input int r, input bit sw);
    return {3'b000, r[13:0], sw, 1'b1};
  endfunction

  function automatic logic [18:0] div_frame(input int a, input int n);
    return {n[10:0], a[6:0], 1'b0};
  endfunction

  task automatic send_bits(input logic [18:0] w, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge clk); ser_data = w[i];
      repeat (4) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk); ser_clk = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_le();
    @(negedge clk); ser_le = 1'b1;
    repeat (4) @(negedge clk); ser_le = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_state(input string req, input int r, input int sw, input int a,
                              input int n, input int e);
    chk(req, "ref_div", ref_div, r);
    chk(req, "presc_sel", presc_sel, sw);
    chk(req, "swallow", swallow, a);
    chk(req, "prog_div", prog_div, n);
    chk(req, "ratio_err", ratio_err, e);
  endtask

  initial begin
    rst_n = 0; ser_data = 0; ser_clk = 0; ser_le = 0;
    repeat (3) @(negedge clk);
    // R9: outputs at zero while reset is held
    expect_state("R9", 0, 0, 0, 0, 0);
    rst_n = 1;
    repeat (6) @(negedge clk);

    // R1 R2 R4: divider frame, MSB first, control bit low
    send_bits(div_frame(5, 100), 19); pulse_le();
    expect_state("R4", 0, 0, 5, 100, 0);

    // R2 R3: reference frame leaves divider latch untouched
    send_bits(ref_frame(1000, 0), 16); pulse_le();
    expect_state("R3", 1000, 0, 5, 100, 0);

    // R5: count 7 rejected, then boundary 8 accepted and R8 clears the flag
    send_bits(ref_frame(7, 1), 16); pulse_le();
    expect_state("R5", 1000, 0, 5, 100, 1);
    send_bits(ref_frame(8, 1), 16); pulse_le();
    expect_state("R8", 8, 1, 5, 100, 0);

    // R6: programmable count 15 rejected, 16 accepted
    send_bits(div_frame(3, 15), 19); pulse_le();
    expect_state("R6", 8, 1, 5, 100, 1);
    send_bits(div_frame(15, 16), 19); pulse_le();
    expect_state("R6", 8, 1, 15, 16, 0);

    // R7: swallow equal to programmable count rejected, maxima accepted
    send_bits(div_frame(20, 20), 19); pulse_le();
    expect_state("R7", 8, 1, 15, 16, 1);
    send_bits(div_frame(127, 2047), 19); pulse_le();
    expect_state("R7", 8, 1, 127, 2047, 0);

    // R3: three stale high bits ahead of a reference frame are ignored
    send_bits({3'b111, ref_frame(16383, 0)}  | 19'h70000, 19); pulse_le();
    expect_state("R3", 16383, 0, 127, 2047, 0);

    // R2: bare load pulse re-transfers the same frame; R8 holds without load
    pulse_le();
    expect_state("R2", 16383, 0, 127, 2047, 0);
    repeat (20) @(negedge clk);
    expect_state("R8", 16383, 0, 127, 2047, 0);

    // R10: latency is checked every cycle by the model comparison
    send_bits(div_frame(1, 3), 19); pulse_le();
    expect_state("R10", 16383, 0, 127, 2047, 1);

    repeat (10) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule